// File: doc/BRIEF.md
# Sticky Receiver Error Status Register

This block gathers seven error and status conditions from a digital audio receiver into one 8-bit status word that software can read. Each condition is sampled only at its own framing boundary. Four conditions follow the sub-frame strobe, two follow the channel-status block strobe, and one follows the Q-subcode block strobe. When a sampled condition shows an error and its bit is enabled in the mask register, the bit latches high. It stays high until a read strobe arrives.

A read clears every latched bit, except a bit whose most recent boundary sample still shows the error. Bits that the mask disables always read zero, and the mask comes out of reset with every bit disabled. The channel-status CRC condition only counts while the receiver reports professional mode. An interrupt line is high whenever any bit of the status word is set.

The upstream decoders (bi-phase decoding, PLL, CRC computation and eye measurement) are not part of this block. It sees them only as level condition inputs.

Top module: `rx_err_status`

## Requirements
- R1: Status bit positions and the boundary each one samples on: bit 0 parity error, bit 1 bi-phase error, bit 2 confidence error, bit 3 validity flag (all on `sf_stb_i`); bit 4 PLL out of lock, bit 5 channel-status CRC error (on `cs_stb_i`); bit 6 Q-subcode CRC error (on `q_stb_i`). `cond_i[k]` feeds status bit k, and 1 means error.
- R2: Status bit 7 always reads 0.
- R3: After reset, the status word is 0, `irq_o` is 0 and every mask bit is disabled, so errors at boundary strobes do not set any bit until the mask is written.
- R4: An enabled bit becomes 1 on the clock edge where its own boundary strobe is high and its condition is 1. A condition with no strobe of its own has no effect.
- R5: A set bit stays set across later boundaries that report no error, for as long as no read occurs.
- R6: On a read strobe, each bit takes the value of its latest boundary sample. That sample includes one taken in the same cycle. A bit whose last sample showed no error is cleared.
- R7: `mask_wdata_i[k]` = 1 enables bit k. A written mask takes effect at the same edge. A disabled bit reads 0 and loses its latched state, so re-enabling it shows 0 until a new error is sampled.
- R8: The channel-status CRC condition (bit 5) is sampled as an error only while `pro_mode_i` is 1.
- R9: An error sampled at a boundary in the same cycle as a read leaves the bit set.
- R10: `irq_o` is 1 exactly when some status bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cond_i | input | 7 | Raw error conditions, bit k feeds status bit k |
| sf_stb_i | input | 1 | Sub-frame boundary strobe |
| cs_stb_i | input | 1 | Channel-status block boundary strobe |
| q_stb_i | input | 1 | Q-subcode block boundary strobe |
| pro_mode_i | input | 1 | Professional mode, qualifies the channel-status CRC condition |
| mask_we_i | input | 1 | Mask register write enable |
| mask_wdata_i | input | 7 | Mask write data, 1 enables a bit |
| rd_i | input | 1 | Status read strobe, clear-on-read |
| status_o | output | 8 | Latched status word |
| irq_o | output | 1 | Any status bit set |

## Verification
The read clear and a boundary sample can fall in the same cycle. The outcome then depends on whether the fresh sample reports an error. The bench covers this by sweeping every condition pattern against every strobe combination, with the read strobe both high and low. It repeats the sweep under several masks, and it also exercises mask writes that coincide with strobes. Each resulting status word and interrupt level is compared against a model in the bench, written from the requirements. Directed cases pin down the collision that sets a bit and the read that clears it.

// File: rtl/rx_err_pkg.sv
package rx_err_pkg;
  localparam int unsigned NUM_ERR = 7;
  localparam int unsigned STAT_W  = NUM_ERR + 1;

  localparam int unsigned B_PAR   = 0;
  localparam int unsigned B_BIP   = 1;
  localparam int unsigned B_CONF  = 2;
  localparam int unsigned B_VAL   = 3;
  localparam int unsigned B_UNLK  = 4;
  localparam int unsigned B_CCRC  = 5;
  localparam int unsigned B_QCRC  = 6;

  typedef enum logic [1:0] {
    DOM_SF = 2'd0,
    DOM_CS = 2'd1,
    DOM_Q  = 2'd2
  } dom_e;

  function automatic dom_e dom_of(input int unsigned idx);
    if (idx == B_QCRC) return DOM_Q;
    if (idx == B_UNLK || idx == B_CCRC) return DOM_CS;
    return DOM_SF;
  endfunction
endpackage

// File: rtl/rx_err_mask_reg.sv
module rx_err_mask_reg #(
  parameter int unsigned W = 7,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] mask_d_o,
  output logic [W-1:0] mask_q_o
);
  logic [W-1:0] mask_q;

  assign mask_d_o = we_i ? wdata_i : mask_q;
  assign mask_q_o = mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= RST_VAL;
    else         mask_q <= mask_d_o;
  end
endmodule

// File: rtl/rx_err_strobe_sel.sv
module rx_err_strobe_sel
  import rx_err_pkg::*;
#(
  parameter int unsigned N = NUM_ERR
) (
  input  logic         sf_stb_i,
  input  logic         cs_stb_i,
  input  logic         q_stb_i,
  input  logic [N-1:0] cond_i,
  input  logic         pro_mode_i,
  output logic [N-1:0] stb_o,
  output logic [N-1:0] cond_o
);
  for (genvar k = 0; k < N; k++) begin : g_bit
    localparam dom_e D = dom_of(k);
    if (D == DOM_Q) begin : g_q
      assign stb_o[k] = q_stb_i;
    end else if (D == DOM_CS) begin : g_cs
      assign stb_o[k] = cs_stb_i;
    end else begin : g_sf
      assign stb_o[k] = sf_stb_i;
    end
    // CS CRC is only meaningful in professional mode
    if (k == B_CCRC) begin : g_pro
      assign cond_o[k] = cond_i[k] & pro_mode_i;
    end else begin : g_raw
      assign cond_o[k] = cond_i[k];
    end
  end
endmodule

// File: rtl/rx_err_cell.sv
module rx_err_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stb_i,
  input  logic cond_i,
  input  logic en_i,
  input  logic rd_i,
  output logic flag_o
);
  logic src_q, flag_q;
  logic keep, flag_d;

  // latest boundary sample, including this cycle's
  assign keep   = stb_i ? cond_i : src_q;
  assign flag_d = en_i & (rd_i ? keep : (flag_q | (stb_i & cond_i)));
  assign flag_o = flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      src_q  <= keep;
      flag_q <= flag_d;
    end
  end
endmodule

// File: rtl/rx_err_status.sv
module rx_err_status
  import rx_err_pkg::*;
#(
  parameter logic [NUM_ERR-1:0] MASK_RST = '0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_ERR-1:0] cond_i,
  input  logic               sf_stb_i,
  input  logic               cs_stb_i,
  input  logic               q_stb_i,
  input  logic               pro_mode_i,
  input  logic               mask_we_i,
  input  logic [NUM_ERR-1:0] mask_wdata_i,
  input  logic               rd_i,
  output logic [STAT_W-1:0]  status_o,
  output logic               irq_o
);
  logic [NUM_ERR-1:0] mask_d, mask_q;
  logic [NUM_ERR-1:0] bit_stb, bit_cond, flags;

  rx_err_mask_reg #(.W(NUM_ERR), .RST_VAL(MASK_RST)) u_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (mask_we_i),
    .wdata_i  (mask_wdata_i),
    .mask_d_o (mask_d),
    .mask_q_o (mask_q)
  );

  rx_err_strobe_sel #(.N(NUM_ERR)) u_sel (
    .sf_stb_i   (sf_stb_i),
    .cs_stb_i   (cs_stb_i),
    .q_stb_i    (q_stb_i),
    .cond_i     (cond_i),
    .pro_mode_i (pro_mode_i),
    .stb_o      (bit_stb),
    .cond_o     (bit_cond)
  );

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_cell
    rx_err_cell u_cell (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .stb_i  (bit_stb[k]),
      .cond_i (bit_cond[k]),
      .en_i   (mask_d[k]),
      .rd_i   (rd_i),
      .flag_o (flags[k])
    );
  end

  assign status_o = {1'b0, flags};
  assign irq_o    = |flags;
endmodule

// File: rtl/rx_err_status_chk.sv
module rx_err_status_chk
  import rx_err_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_ERR-1:0] cond_i,
  input logic               sf_stb_i,
  input logic               cs_stb_i,
  input logic               q_stb_i,
  input logic               pro_mode_i,
  input logic               mask_we_i,
  input logic               rd_i,
  input logic [STAT_W-1:0]  status_o,
  input logic               irq_o,
  input logic [NUM_ERR-1:0] mask_q
);
  // R7
  masked_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[NUM_ERR-1:0] & ~mask_q) == '0);

  // R5
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !mask_we_i) |=>
      ((status_o[NUM_ERR-1:0] & $past(status_o[NUM_ERR-1:0])) == $past(status_o[NUM_ERR-1:0])));

  // R4
  no_stb_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sf_stb_i && !cs_stb_i && !q_stb_i && !rd_i && !mask_we_i) |=> $stable(status_o));

  // R9
  rd_collide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sf_stb_i && cond_i[B_PAR] && mask_q[B_PAR] && !mask_we_i) |=> status_o[B_PAR]);

  // R8
  pro_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_stb_i && !pro_mode_i && !rd_i && !status_o[B_CCRC]) |=> !status_o[B_CCRC]);

  // R10
  irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(sf_stb_i || cs_stb_i || q_stb_i));
endmodule

bind rx_err_status rx_err_status_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cond_i     (cond_i),
  .sf_stb_i   (sf_stb_i),
  .cs_stb_i   (cs_stb_i),
  .q_stb_i    (q_stb_i),
  .pro_mode_i (pro_mode_i),
  .mask_we_i  (mask_we_i),
  .rd_i       (rd_i),
  .status_o   (status_o),
  .irq_o      (irq_o),
  .mask_q     (mask_q)
);

// File: tb/sim_rx_err_status.sv
module sim_rx_err_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] cond = '0;
  logic       sf = 1'b0, cs = 1'b0, qs = 1'b0, pro = 1'b0, we = 1'b0, rd = 1'b0;
  logic [6:0] wd = '0;
  logic [7:0] status;
  logic       irq;

  int unsigned n_tot = 0, n_fail = 0;
  logic [6:0] m_mask = '0, m_src = '0, m_stk = '0;

  always #2.5 clk = ~clk;

  rx_err_status u0 (
    .clk_i(clk), .rst_ni(rst_n), .cond_i(cond), .sf_stb_i(sf), .cs_stb_i(cs),
    .q_stb_i(qs), .pro_mode_i(pro), .mask_we_i(we), .mask_wdata_i(wd),
    .rd_i(rd), .status_o(status), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tot++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, update model, sample 1 ns after the edge
  task automatic cyc(input logic [6:0] c, input logic s_sf, input logic s_cs, input logic s_q,
                     input logic p, input logic w, input logic [6:0] wdv, input logic r);
    logic [6:0] nm;
    @(negedge clk);
    cond = c; sf = s_sf; cs = s_cs; qs = s_q; pro = p; we = w; wd = wdv; rd = r;
    nm = w ? wdv : m_mask;
    for (int k = 0; k < 7; k++) begin
      logic s, e, keep;
      s = (k < 4) ? s_sf : (k < 6) ? s_cs : s_q;
      e = c[k] & ((k == 5) ? p : 1'b1);
      keep = s ? e : m_src[k];
      m_stk[k] = nm[k] & (r ? keep : (m_stk[k] | (s & e)));
      m_src[k] = keep;
    end
    m_mask = nm;
    @(posedge clk);
    #1;
    cond = '0; sf = 0; cs = 0; qs = 0; we = 0; rd = 0;
  endtask

  task automatic look(input string tag);
    chk(tag, status, {1'b0, m_stk});
    chk("R10", {7'd0, irq}, {7'd0, |m_stk});
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    n_fail++; n_tot++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  initial begin
    #12 rst_n = 1'b1;
    #1;
    // R3 reset state
    chk("R3", status, 8'h00);
    chk("R3", {7'd0, irq}, 8'h00);
    cyc(7'h7F, 1, 1, 1, 1, 0, 0, 0);
    chk("R3", status, 8'h00);
    // R7 enable all, nothing set yet
    cyc(0, 0, 0, 0, 0, 1, 7'h7F, 0);
    chk("R7", status, 8'h00);
    // R1 / R4 per-bit placement and strobe domain
    for (int k = 0; k < 7; k++) begin
      logic [6:0] b;
      b = 7'(1 << k);
      if (k < 4)      cyc(b, 0, 1, 1, 1, 0, 0, 0);
      else if (k < 6) cyc(b, 1, 0, 1, 1, 0, 0, 0);
      else            cyc(b, 1, 1, 0, 1, 0, 0, 0);
      chk("R4", status, 8'h00);
      cyc(b, k < 4, k == 4 || k == 5, k == 6, 1, 0, 0, 0);
      chk("R1", status, {1'b0, b});
      // R5 clean boundaries keep it
      cyc(0, 1, 1, 1, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 1, 0, 0, 0);
      chk("R5", status, {1'b0, b});
      // R6 last sample clean -> read clears
      cyc(0, 0, 0, 0, 1, 0, 0, 1);
      chk("R6", status, 8'h00);
    end
    // R8 CS CRC ignored outside professional mode
    cyc(7'h20, 0, 1, 0, 0, 0, 0, 0);
    chk("R8", status, 8'h00);
    // R6 source still true survives read
    cyc(7'h01, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R6", status, 8'h01);
    cyc(0, 1, 0, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0, 0, 0, 1);
    chk("R6", status, 8'h00);
    // R9 error at boundary together with read
    cyc(7'h41, 1, 0, 1, 0, 0, 0, 1);
    chk("R9", status, 8'h41);
    chk("R10", {7'd0, irq}, 8'h01);
    // R7 masking drops and forgets the bit
    cyc(0, 0, 0, 0, 0, 1, 7'h3E, 0);
    chk("R7", status, 8'h00);
    cyc(0, 0, 0, 0, 0, 1, 7'h7F, 0);
    chk("R7", status, 8'h00);
    // R2 and sweep under several masks (R1, R6, R9, R10)
    foreach (m_sweep[i]) begin
      cyc(0, 1, 1, 1, 0, 1, m_sweep[i], 1);
      for (int c = 0; c < 128; c++)
        for (int s = 0; s < 8; s++)
          for (int r = 0; r < 2; r++) begin
            cyc(7'(c), s[0], s[1], s[2], s[0] ^ c[6], (c == 5 && s == 3), 7'(c ^ 7'h7F), r[0]);
            look("R1");
            chk("R2", {7'd0, status[7]}, 8'h00);
          end
    end
    $display("%0d/%0d checks passed", n_tot - n_fail, n_tot);
    $finish;
  end

  logic [6:0] m_sweep [4] = '{7'h7F, 7'h55, 7'h2A, 7'h00};
endmodule